// File: doc/BRIEF.md
# Two-Sample Accumulator Controller

This block is a small hardwired processor: a controller plus a datapath that adds two input samples taken in consecutive cycles and presents their sum. A one-cycle `go` pulse, or a held level, starts a run. The datapath holds one sum register with clear and load controls. An adder takes the register output and the sample input. A gate passes the register to the result port only while the output enable is set.

The controller has four phases: idle, first add, second add and show. Each phase drives a fixed three-bit control word. The most significant bit clears the sum, the middle bit loads the adder result, and the least significant bit enables the output. The sum register is one bit wider than the sample, so the sum of any two samples fits. A parameter chooses between a binary-coded and a one-hot state register, and both behave the same at the ports.

Top module: `pairsum_fsmd`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters the idle phase and clears the sum. After that edge `ctl_word` reads 3'b100, `y_out` reads 0 and `y_vld` reads 0.
- R2: In the idle phase, a rising edge with `go` low leaves the block idle, with `ctl_word` at 3'b100.
- R3: In the idle phase, a rising edge with `go` high moves the block to the first add phase. The phases then advance without condition, one per edge: first add (3'b010), second add (3'b010), show (3'b001).
- R4: In the show phase `y_out` equals x1 + x2, computed at DATA_W+1 bits with no wrap. Here x1 is `x_in` at the edge that ends the first add phase, and x2 is `x_in` at the edge that ends the second add phase.
- R5: `y_vld` is high only in the show phase. In every other phase `y_out` reads 0.
- R6: After the show phase the block returns to idle on the next edge, whatever `go` is. `go` has no effect during the add and show phases.
- R7: The sum is cleared in the idle phase, so no result depends on an earlier run or on a run cut short by reset.
- R8: `ctl_word` always has exactly one bit set.
- R9: The binary-coded (ONE_HOT=0) and one-hot (ONE_HOT=1) variants produce identical `ctl_word`, `y_out` and `y_vld` on every cycle for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled only in the idle phase |
| x_in | input | DATA_W | Sample input, held stable by the driver through each add phase |
| y_out | output | DATA_W+1 | Sum of the two samples, zero outside the show phase |
| y_vld | output | 1 | High during the show phase |
| ctl_word | output | 3 | Control word {clear, load, output enable} |

## Verification
A start seen at edge N puts the block in the first add phase after edge N. The second add phase follows after N+1, and the sum appears on `y_out` with `y_vld` after N+2. The block is idle again after N+3. The bench drives inputs on falling edges and checks each phase on the falling edge after the rising edge that produced it, so every check lands exactly where the registers place the result. The reset, ignore and clear checks sample the ports on the cycle just after the stimulus, before the next one is applied.

// File: rtl/pairsum_pkg.sv
package pairsum_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ACC_A = 2'd1,
      PH_ACC_B = 2'd2,
      PH_SHOW  = 2'd3
   } phase_e;

   typedef struct packed {
      logic clr;
      logic ld;
      logic oe;
   } ctl_t;

   localparam ctl_t CW_IDLE = 3'b100;
   localparam ctl_t CW_ACC  = 3'b010;
   localparam ctl_t CW_SHOW = 3'b001;

   localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/pairsum_ctrl.sv
module pairsum_ctrl
   import pairsum_pkg::*;
#(
   parameter int unsigned ONE_HOT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic go,
   output ctl_t ctl
);

   localparam int unsigned HOT_W = NUM_PHASES;

   phase_e cur;

   generate
      if (ONE_HOT > 1) begin : g_bad_sel
         $error("pairsum_ctrl: ONE_HOT must be 0 or 1");
      end

      if (ONE_HOT == 1) begin : g_onehot
         logic [HOT_W-1:0] hot_q;
         logic [HOT_W-1:0] hot_d;

         always_comb begin
            hot_d    = '0;
            hot_d[0] = (hot_q[0] & ~go) | hot_q[3];
            hot_d[1] = hot_q[0] & go;
            hot_d[2] = hot_q[1];
            hot_d[3] = hot_q[2];
         end

         always_ff @(posedge clk) begin
            if (rst) hot_q <= {{(HOT_W-1){1'b0}}, 1'b1};
            else     hot_q <= hot_d;
         end

         always_comb begin
            case (hot_q)
               4'b0010: cur = PH_ACC_A;
               4'b0100: cur = PH_ACC_B;
               4'b1000: cur = PH_SHOW;
               default: cur = PH_IDLE;
            endcase
         end

         AST_HOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
            $onehot(hot_q)); // R8
      end else begin : g_binary
         phase_e cur_q;
         phase_e nxt;

         always_comb begin
            case (cur_q)
               PH_IDLE:  nxt = go ? PH_ACC_A : PH_IDLE;
               PH_ACC_A: nxt = PH_ACC_B;
               PH_ACC_B: nxt = PH_SHOW;
               PH_SHOW:  nxt = PH_IDLE;
               default:  nxt = PH_IDLE;
            endcase
         end

         always_ff @(posedge clk) begin
            if (rst) cur_q <= PH_IDLE;
            else     cur_q <= nxt;
         end

         assign cur = cur_q;
      end
   endgenerate

   always_comb begin
      case (cur)
         PH_ACC_A: ctl = CW_ACC;
         PH_ACC_B: ctl = CW_ACC;
         PH_SHOW:  ctl = CW_SHOW;
         default:  ctl = CW_IDLE;
      endcase
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_IDLE && !go) |=> (cur == PH_IDLE)); // R2
   AST_START_STEP: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_IDLE && go) |=> (cur == PH_ACC_A)); // R3
   AST_ADD_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_ACC_A) |=> (cur == PH_ACC_B)); // R3
   AST_TO_SHOW: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_ACC_B) |=> (cur == PH_SHOW)); // R3
   AST_BACK_IDLE: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_SHOW) |=> (cur == PH_IDLE)); // R6

endmodule

// File: rtl/pairsum_dp.sv
module pairsum_dp #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              ld,
   input  logic [DATA_W-1:0] x,
   output logic [DATA_W:0]   sum
);

   localparam int unsigned SUM_W = DATA_W + 1;

   logic [SUM_W-1:0] add_out;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pairsum_dp: DATA_W must be at least 1");
      end
   endgenerate

   assign add_out = sum + {1'b0, x};

   always_ff @(posedge clk) begin
      if (rst || clr) sum <= '0;
      else if (ld)    sum <= add_out;
   end

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
      clr |=> (sum == '0)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (ld && !clr) |=> (sum >= $past(sum))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!ld && !clr) |=> $stable(sum)); // R4

endmodule

// File: rtl/pairsum_outgate.sv
module pairsum_outgate #(
   parameter int unsigned DATA_W = 8
) (
   input  logic            oe,
   input  logic [DATA_W:0] sum,
   output logic [DATA_W:0] y,
   output logic            vld
);

   assign y   = oe ? sum : '0;
   assign vld = oe;

endmodule

// File: rtl/pairsum_fsmd.sv
module pairsum_fsmd
   import pairsum_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ONE_HOT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic [DATA_W-1:0] x_in,
   output logic [DATA_W:0]   y_out,
   output logic              y_vld,
   output logic [2:0]        ctl_word
);

   ctl_t            ctl;
   logic [DATA_W:0] sum;

   pairsum_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
      .clk (clk),
      .rst (rst),
      .go  (go),
      .ctl (ctl)
   );

   pairsum_dp #(.DATA_W(DATA_W)) u_dp (
      .clk (clk),
      .rst (rst),
      .clr (ctl.clr),
      .ld  (ctl.ld),
      .x   (x_in),
      .sum (sum)
   );

   pairsum_outgate #(.DATA_W(DATA_W)) u_gate (
      .oe  (ctl.oe),
      .sum (sum),
      .y   (y_out),
      .vld (y_vld)
   );

   assign ctl_word = ctl;

   AST_CTL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(ctl_word) == 1); // R8
   AST_VLD_ONLY_SHOW: assert property (@(posedge clk) disable iff (rst)
      y_vld |-> (ctl_word == 3'b001)); // R5
   AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
      !y_vld |-> (y_out == '0)); // R5
   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      y_vld |=> !y_vld); // R6

endmodule

// File: tb/pairsum_fsmd_tb.sv
`timescale 1ns/1ps
module pairsum_fsmd_tb;

   localparam int unsigned DW = 8;
   localparam int unsigned NV = 8;
   localparam logic [2*DW-1:0] VEC [0:NV-1] = '{
      16'h0000, 16'h0102, 16'hFF01, 16'h80_80,
      16'h5A_A5, 16'h00FF, 16'h7F_01, 16'h33_44
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          go  = 1'b0;
   logic [DW-1:0] x   = '0;
   logic [DW:0]   y_b, y_h;
   logic          v_b, v_h;
   logic [2:0]    c_b, c_h;

   int n_cmp  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pairsum_fsmd #(.DATA_W(DW), .ONE_HOT(0)) u_dut (
      .clk(clk), .rst(rst), .go(go), .x_in(x),
      .y_out(y_b), .y_vld(v_b), .ctl_word(c_b));

   pairsum_fsmd #(.DATA_W(DW), .ONE_HOT(1)) u_dut_oh (
      .clk(clk), .rst(rst), .go(go), .x_in(x),
      .y_out(y_h), .y_vld(v_h), .ctl_word(c_h));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R9: both variants must agree on every cycle
   always @(negedge clk) begin
      if (!done) check("R9 variants agree", {y_h, v_h, c_h}, {y_b, v_b, c_b});
   end

   task automatic run_pair(logic [DW-1:0] a, logic [DW-1:0] b, logic go_busy);
      @(negedge clk); go = 1'b1; x = a;
      @(negedge clk);
      check("R3 first add word", c_b, 3'b010);
      check("R5 quiet during add", {y_b, v_b}, '0);
      go = go_busy; x = a;
      @(negedge clk);
      check("R3 second add word", c_b, 3'b010);
      x = b;
      @(negedge clk);
      check("R3 show word", c_b, 3'b001);
      check("R4 sum", y_b, {1'b0, a} + {1'b0, b});
      check("R5 valid in show", v_b, 1'b1);
      go = 1'b0;
      @(negedge clk);
      check("R6 back to idle", c_b, 3'b100);
      check("R5 quiet after show", {y_b, v_b}, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset word", c_b, 3'b100);
      check("R1 reset outputs", {y_b, v_b}, '0);
      rst = 1'b0;

      // R2: idle holds while go is low
      x = 8'hAA;
      repeat (4) begin
         @(negedge clk);
         check("R2 idle hold", c_b, 3'b100);
         check("R5 idle quiet", {y_b, v_b}, '0);
      end

      // Table walk: R4 and R7 (each run starts from a cleared sum)
      for (int i = 0; i < NV; i++) begin
         run_pair(VEC[i][2*DW-1:DW], VEC[i][DW-1:0], 1'b0);
      end

      // R4: widest sum, no wrap
      run_pair(8'hFF, 8'hFF, 1'b0);

      // R6: go held high through the add and show phases is ignored
      run_pair(8'h12, 8'h34, 1'b1);

      // R7: reset in mid-run, then a fresh run is unaffected
      @(negedge clk); go = 1'b1; x = 8'hF0;
      @(negedge clk); go = 1'b0;
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check("R1 reset mid-run word", c_b, 3'b100);
      check("R1 reset mid-run outputs", {y_b, v_b}, '0);
      rst = 1'b0;
      run_pair(8'h03, 8'h04, 1'b0);

      // R3: go held across a whole run restarts after one idle cycle
      @(negedge clk); go = 1'b1; x = 8'h01;
      @(negedge clk); x = 8'h01;
      @(negedge clk); x = 8'h02;
      @(negedge clk);
      check("R4 sum continuous go", y_b, 9'd3);
      @(negedge clk);
      check("R6 idle between runs", c_b, 3'b100);
      @(negedge clk);
      check("R3 restart from held go", c_b, 3'b010);
      go = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 settled idle", c_b, 3'b100);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_miss++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
         $finish;
      end
   end

endmodule